// File: doc/BRIEF.md
# Indirect Branch Landing-Pad Checker

This block watches the stream of retiring instructions and enforces forward-edge control-flow integrity. Some indirect register jumps or calls set an internal "landing pad expected" flag. When the flag is set, the next retired instruction must be a correctly placed landing-pad marker. If it is not, the block raises an exception request for that instruction.

Three source registers are exempt from tracking. Jumps through x1 or x5 are treated as returns. A jump through x7 is treated as a software-guarded far jump. A landing pad can carry a 20-bit label. When the label is nonzero, it must match bits 31:12 of x7. All checking is gated by a tracking-enable input. The exception request is combinational on the retiring instruction, so it sits in the same cycle as that instruction's valid.

Top module: `lpad_guard`

## Requirements
- R1: A synchronous active-high reset clears the pending expectation. After reset, a non-landing-pad instruction raises no exception.
- R2: An indirect jump whose source register is x1 or x5 does not arm the expectation.
- R3: An indirect jump whose source register is x7 does not arm the expectation.
- R4: An indirect jump through any other register arms the expectation when tracking is on. If the next retired instruction is not a landing pad, `exc_req` is raised with `exc_cause`=18 and `exc_tval`=2.
- R5: A landing pad is an instruction with bits 6:0 = 7'b0010111 and bits 11:7 = 0. The same opcode with a nonzero destination is not a landing pad.
- R6: An expected landing pad whose PC bits 1:0 are not both zero is a violation.
- R7: A landing pad whose label (bits 31:12) is zero passes for any value of x7.
- R8: A nonzero label must equal x7 bits 31:12, and x7 bits above 31 are ignored. A mismatch is a violation.
- R9: While `trk_en` is low, no exception is raised and the expectation is cleared and cannot be armed.
- R10: A landing pad retired with no expectation pending raises nothing, whatever its label or alignment.
- R11: `exc_req` is asserted only together with `ret_valid`, for one cycle. Any retired instruction, and any exception, clears the expectation. `exc_cause` and `exc_tval` read zero when `exc_req` is low.
- R12: Cycles without `ret_valid` leave the expectation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trk_en | input | 1 | Tracking enable |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_insn | input | 32 | Retiring instruction word |
| ret_pc | input | XLEN | Retiring instruction address |
| ret_ijmp | input | 1 | Retiring instruction is an indirect register jump or call |
| ret_rs1 | input | 5 | Source register index of the indirect jump |
| x7_val | input | XLEN | Current value of x7 |
| exc_req | output | 1 | Exception request for the retiring instruction |
| exc_cause | output | CAUSE_W | Cause code (18 when raised) |
| exc_tval | output | XLEN | Trap value (2 when raised) |

## Verification
The bench tries the block with three kinds of input pattern.

- Directed jump/landing-pad pairs through each exempt register and a plain one. These separate exempt sources from arming ones.
- Landing pads with a zero label, a matching label, a mismatching label, a label that matches only when the upper x7 bits are ignored, and a misaligned PC. These separate the three violation kinds from passing pads.
- Bubbles, tracking toggled off while armed, and mid-run reset. These show the expectation is held, dropped, or cleared as required.

A long random stream then mixes all of these and is compared against a reference model in the bench.

// File: rtl/lpad_guard.sv
module lpad_guard #(
  parameter int XLEN = 64,
  parameter int CAUSE_W = 8,
  parameter logic [CAUSE_W-1:0] CAUSE_SWCHK = 18,
  parameter logic [XLEN-1:0] TVAL_LPAD = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trk_en,
  input  logic               ret_valid,
  input  logic [31:0]        ret_insn,
  input  logic [XLEN-1:0]    ret_pc,
  input  logic               ret_ijmp,
  input  logic [4:0]         ret_rs1,
  input  logic [XLEN-1:0]    x7_val,
  output logic               exc_req,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    exc_tval
);
  localparam logic [6:0] OP_AUIPC = 7'b0010111;

  logic pend;

  wire        is_pad  = (ret_insn[6:0] == OP_AUIPC) && (ret_insn[11:7] == 5'd0);
  wire [19:0] label   = ret_insn[31:12];
  wire        misal   = |ret_pc[1:0];
  wire        tag_bad = (label != 20'd0) && (label != x7_val[31:12]);
  wire        exempt  = (ret_rs1 == 5'd1) || (ret_rs1 == 5'd5) || (ret_rs1 == 5'd7);
  wire        viol    = !is_pad || misal || tag_bad;

  assign exc_req   = ret_valid && trk_en && pend && viol;
  assign exc_cause = exc_req ? CAUSE_SWCHK : '0;
  assign exc_tval  = exc_req ? TVAL_LPAD : '0;

  always_ff @(posedge clk) begin
    if (rst)            pend <= 1'b0;
    else if (!trk_en)   pend <= 1'b0;
    else if (ret_valid) pend <= ret_ijmp && !exempt && !exc_req;
  end

  // R11
  exc_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> ret_valid);

  // R9
  exc_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> trk_en);

  // R11
  exc_single_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> !exc_req);

  // R2
  ret_exempt_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_ijmp && (ret_rs1 == 5'd1 || ret_rs1 == 5'd5)) |=> !exc_req);

  // R3
  x7_exempt_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_ijmp && ret_rs1 == 5'd7) |=> !exc_req);

  // R12
  bubble_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ret_valid && trk_en) |=> $stable(pend));

  // R9
  off_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !trk_en |=> !pend);
endmodule

// File: tb/sim_lpad_guard.sv
module sim_lpad_guard;
  logic clk = 0, rst = 1, trk_en = 0, ret_valid = 0, ret_ijmp = 0;
  logic [31:0] ret_insn = 0;
  logic [63:0] ret_pc = 0, x7_val = 0;
  logic [4:0] ret_rs1 = 0;
  logic exc_req;
  logic [7:0] exc_cause;
  logic [63:0] exc_tval;
  int total = 0, bad = 0;
  bit m_pend = 0;

  always #2.5 clk = ~clk;

  lpad_guard u0 (.clk(clk), .rst(rst), .trk_en(trk_en), .ret_valid(ret_valid),
    .ret_insn(ret_insn), .ret_pc(ret_pc), .ret_ijmp(ret_ijmp), .ret_rs1(ret_rs1),
    .x7_val(x7_val), .exc_req(exc_req), .exc_cause(exc_cause), .exc_tval(exc_tval));

  function automatic bit [31:0] pad(bit [19:0] l); return {l, 5'd0, 7'h17}; endfunction
  localparam bit [31:0] NOP = 32'h00000013;

  function automatic bit m_viol(bit [31:0] i, bit [63:0] p, bit [63:0] x);
    bit ispad = (i[6:0] == 7'h17) && (i[11:7] == 0);
    bit lbad  = (i[31:12] != 0) && (i[31:12] != x[31:12]);
    return !ispad || (p[1:0] != 0) || lbad;
  endfunction

  task automatic step(string tag, bit v, bit [31:0] ins, bit [63:0] p,
                      bit ij, bit [4:0] r, bit [63:0] x, bit en);
    bit e;
    bit [7:0] ec;
    bit [63:0] et;
    @(negedge clk);
    ret_valid = v; ret_insn = ins; ret_pc = p; ret_ijmp = ij; ret_rs1 = r;
    x7_val = x; trk_en = en;
    #1;
    e  = v && en && m_pend && m_viol(ins, p, x);
    ec = e ? 8'd18 : 8'd0;
    et = e ? 64'd2 : 64'd0;
    total++;
    if (exc_req !== e || exc_cause !== ec || exc_tval !== et) begin
      bad++;
      $display("FAIL %s: exc=%0b cause=%0d tval=%0d expected exc=%0b cause=%0d tval=%0d",
               tag, exc_req, exc_cause, exc_tval, e, ec, et);
    end
    if (!en) m_pend = 0;
    else if (v) m_pend = ij && !(r == 1 || r == 5 || r == 7) && !e;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; ret_valid = 0;
    @(negedge clk); rst = 0; m_pend = 0;
  endtask

  initial begin
    #500us;
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    step("R1", 1, NOP, 0, 0, 0, 0, 1);
    // R4 arm via x10, missing pad
    step("R4", 1, NOP, 0, 1, 10, 0, 1);
    step("R4", 1, NOP, 4, 0, 0, 0, 1);
    // R11 pending cleared after exception
    step("R11", 1, NOP, 8, 0, 0, 0, 1);
    // R2 exempt x1 and x5
    step("R2", 1, NOP, 0, 1, 1, 0, 1);
    step("R2", 1, NOP, 4, 0, 0, 0, 1);
    step("R2", 1, NOP, 0, 1, 5, 0, 1);
    step("R2", 1, NOP, 4, 0, 0, 0, 1);
    // R3 exempt x7
    step("R3", 1, NOP, 0, 1, 7, 0, 1);
    step("R3", 1, NOP, 4, 0, 0, 0, 1);
    // R7 zero label
    step("R7", 1, NOP, 0, 1, 6, 64'h1234_5000, 1);
    step("R7", 1, pad(0), 64'h100, 0, 0, 64'h1234_5000, 1);
    // R8 matching label, upper x7 bits ignored
    step("R8", 1, NOP, 0, 1, 6, 0, 1);
    step("R8", 1, pad(20'hABCDE), 64'h100, 0, 0, 64'hFFFF_0000_ABCD_E123, 1);
    // R8 mismatch
    step("R8", 1, NOP, 0, 1, 6, 0, 1);
    step("R8", 1, pad(20'hABCDE), 64'h100, 0, 0, 64'h0000_0000_ABCD_F000, 1);
    // R6 misaligned
    step("R6", 1, NOP, 0, 1, 6, 0, 1);
    step("R6", 1, pad(0), 64'h102, 0, 0, 0, 1);
    // R5 auipc with rd!=0 is not a pad
    step("R5", 1, NOP, 0, 1, 6, 0, 1);
    step("R5", 1, {20'd0, 5'd3, 7'h17}, 64'h100, 0, 0, 0, 1);
    // R10 unarmed pad, misaligned with bad label
    step("R10", 1, pad(20'h00001), 64'h103, 0, 0, 0, 1);
    // R12 bubbles keep expectation
    step("R12", 1, NOP, 0, 1, 6, 0, 1);
    step("R12", 0, NOP, 4, 0, 0, 0, 1);
    step("R12", 0, NOP, 4, 0, 0, 0, 1);
    step("R12", 1, NOP, 4, 0, 0, 0, 1);
    // R9 tracking off: no exception, expectation dropped
    step("R9", 1, NOP, 0, 1, 6, 0, 1);
    step("R9", 1, NOP, 4, 0, 0, 0, 0);
    step("R9", 1, NOP, 8, 0, 0, 0, 1);
    step("R9", 1, NOP, 0, 1, 6, 0, 0);
    step("R9", 1, NOP, 4, 0, 0, 0, 1);
    // R1 mid-run reset clears expectation
    step("R1", 1, NOP, 0, 1, 6, 0, 1);
    do_reset();
    step("R1", 1, NOP, 4, 0, 0, 0, 1);
    // random mix
    void'($urandom(32'd1357));
    for (int n = 0; n < 4000; n++) begin
      bit [63:0] x = {$urandom, $urandom};
      bit [31:0] ins;
      bit [63:0] p = {$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_FFFC;
      bit [4:0] r;
      int k = $urandom_range(0, 9);
      case ($urandom_range(0, 3))
        0: ins = pad(0);
        1: ins = pad(x[31:12]);
        2: ins = pad(20'($urandom));
        default: ins = $urandom;
      endcase
      if ($urandom_range(0, 9) == 0) p[1:0] = 2'($urandom_range(1, 3));
      r = (k < 3) ? ((k == 0) ? 5'd1 : (k == 1) ? 5'd5 : 5'd7) : 5'($urandom);
      step("R4", $urandom_range(0, 7) != 0, ins, p, $urandom_range(0, 1), r, x,
           $urandom_range(0, 15) != 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule